// File: doc/BRIEF.md
# Watchdog timer with clock-frequency recovery

This block is a watchdog for a programmable clock generator. Firmware holds its controls in register fields: a run enable, a time-base select, a 3-bit timeout multiple, a choice between "reset only" and "reset and restore frequency", and a choice of which frequency code to restore. A one-cycle write strobe, `cfg_wr`, marks each write of those fields. A write with the enable set starts the count, and each later such write services it. If firmware stops servicing, the count expires. The block then sets an alarm flag and sends one fixed-length system reset pulse.

Frequency restore is optional. When it is selected, the block captures a recovery frequency code at expiry and drives it on `freq_code` in place of the software-selected code. The captured code is either the hardware-strapped code or a programmed recovery code. The clock generator keeps that frequency until firmware writes the control fields again.

The time base comes from the input clock through a prescaler set by `CLK_KHZ`. One unit is 294 ms on the short time base and 2.34 s on the long one.

Top module: `wdt_freq_recover`

## Requirements
- R1: After reset, `alarm` and `sys_reset` are 0 and `freq_code` equals `sw_code`.
- R2: A write with `wd_enable`=1 and `timeout_mult`=M (1..7) makes `sys_reset` rise exactly M×U clock cycles after the write cycle. U is 294×CLK_KHZ cycles when `scale_long`=0 and 2340×CLK_KHZ cycles when `scale_long`=1.
- R3: `timeout_mult`=000 is a test mode. The count expires after a single unit U instead of acting as a normal timeout.
- R4: Another write with `wd_enable`=1 while the count is running restarts the full period, measured from that write.
- R5: While `wd_enable` is 0 the count is stopped. No expiry, alarm or reset pulse occurs.
- R6: `alarm` goes to 1 at expiry. It stays 1 until a write whose `timeout_mult` field is 000, which clears it.
- R7: Each expiry produces one `sys_reset` pulse that is high for exactly RST_LEN consecutive cycles.
- R8: If `action_reset_only`=0 at expiry, `freq_code` switches to a recovery code in the same cycle as `sys_reset` rises. If it is 1, `freq_code` keeps following `sw_code`.
- R9: The recovery code is `hw_code` when `recover_from_prog`=0 and `prog_code` when it is 1. Both are captured at expiry.
- R10: After a recovery, the next write returns `freq_code` to `sw_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle strobe marking a write of the control fields |
| wd_enable | input | 1 | Watchdog run enable |
| scale_long | input | 1 | Time base: 0 short unit, 1 long unit |
| timeout_mult | input | 3 | Timeout in units; 000 is test mode |
| action_reset_only | input | 1 | 1: reset only; 0: reset and restore frequency |
| recover_from_prog | input | 1 | Restore source: 0 hardware code, 1 programmed code |
| sw_code | input | CODE_W | Software-selected frequency code |
| hw_code | input | CODE_W | Hardware-latched frequency code |
| prog_code | input | CODE_W | Programmed recovery frequency code |
| alarm | output | 1 | Sticky timeout flag |
| sys_reset | output | 1 | System reset pulse |
| freq_code | output | CODE_W | Frequency code currently in effect |

## Verification
The assertions assume that the control fields change only together with a `cfg_wr` strobe, as register contents would. They also assume that RST_LEN is shorter than one time unit, so that reset pulses cannot overlap. The bench drives every field change inside its write task, which keeps the first assumption. It runs with CLK_KHZ=1 and RST_LEN=4, which keeps the second. Random trials choose the multiple, the time base, the action, the source and the codes. The long time base is picked only rarely, to keep the run short.

// File: rtl/wdt_freq_recover.sv
module wdt_freq_recover #(
  parameter int CLK_KHZ = 14318,
  parameter int RST_LEN = 16,
  parameter int CODE_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              wd_enable,
  input  logic              scale_long,
  input  logic [2:0]        timeout_mult,
  input  logic              action_reset_only,
  input  logic              recover_from_prog,
  input  logic [CODE_W-1:0] sw_code,
  input  logic [CODE_W-1:0] hw_code,
  input  logic [CODE_W-1:0] prog_code,
  output logic              alarm,
  output logic              sys_reset,
  output logic [CODE_W-1:0] freq_code
);
  localparam int SHORT_CYC = CLK_KHZ * 294;
  localparam int LONG_CYC  = CLK_KHZ * 2340;
  localparam int PW        = $clog2(LONG_CYC + 1);
  localparam int RW        = $clog2(RST_LEN + 1);

  logic [PW-1:0]     pre_q;
  logic [2:0]        units_q;
  logic              running_q;
  logic              alarm_q;
  logic [RW-1:0]     rst_q;
  logic              recov_q;
  logic [CODE_W-1:0] rec_code_q;

  wire [PW-1:0] unit_last = scale_long ? PW'(LONG_CYC - 1) : PW'(SHORT_CYC - 1);
  wire load   = cfg_wr && wd_enable;
  wire tick   = running_q && wd_enable && !cfg_wr && (pre_q >= unit_last);
  wire expire = tick && (units_q == 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      pre_q     <= '0;
      units_q   <= '0;
    end else if (load) begin
      running_q <= 1'b1;
      pre_q     <= '0;
      units_q   <= (timeout_mult == 3'd0) ? 3'd1 : timeout_mult;
    end else if (!wd_enable) begin
      running_q <= 1'b0;
    end else if (running_q) begin
      if (tick) begin
        pre_q <= '0;
        if (expire) running_q <= 1'b0;
        else        units_q   <= units_q - 3'd1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q    <= 1'b0;
      rst_q      <= '0;
      recov_q    <= 1'b0;
      rec_code_q <= '0;
    end else begin
      if (expire)                                alarm_q <= 1'b1;
      else if (cfg_wr && timeout_mult == 3'd0)   alarm_q <= 1'b0;

      if (expire)              rst_q <= RW'(RST_LEN);
      else if (rst_q != '0)    rst_q <= rst_q - 1'b1;

      if (expire && !action_reset_only) begin
        recov_q    <= 1'b1;
        rec_code_q <= recover_from_prog ? prog_code : hw_code;
      end else if (cfg_wr) begin
        recov_q    <= 1'b0;
      end
    end
  end

  assign alarm     = alarm_q;
  assign sys_reset = (rst_q != '0);
  assign freq_code = recov_q ? rec_code_q : sw_code;

  int hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= 0;
    else        hi_run <= sys_reset ? hi_run + 1 : 0;
  end

  assert_pulse_sets_alarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset) |-> alarm);

  assert_alarm_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !(cfg_wr && timeout_mult == 3'd0)) |=> alarm);

  assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_enable |=> !$rose(sys_reset));

  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_reset) |-> (hi_run == RST_LEN));

  assert_recovery_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sys_reset) && !$past(action_reset_only)) |->
      (freq_code == ($past(recover_from_prog) ? $past(prog_code) : $past(hw_code))));

  assert_no_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sys_reset) && $past(action_reset_only) && !$past(cfg_wr) &&
     $past(freq_code) == $past(sw_code)) |-> (freq_code == sw_code));
endmodule

// File: tb/wdt_freq_recover_tb.sv
module wdt_freq_recover_tb;
  localparam int KHZ = 1;
  localparam int RLEN = 4;
  localparam int CW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, wd_enable = 1'b0, scale_long = 1'b1;
  logic [2:0] timeout_mult = 3'd0;
  logic action_reset_only = 1'b0, recover_from_prog = 1'b0;
  logic [CW-1:0] sw_code = 9'h055, hw_code = 9'h0A3, prog_code = 9'h1C7;
  logic alarm, sys_reset;
  logic [CW-1:0] freq_code;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdt_freq_recover #(.CLK_KHZ(KHZ), .RST_LEN(RLEN), .CODE_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wd_enable(wd_enable),
    .scale_long(scale_long), .timeout_mult(timeout_mult),
    .action_reset_only(action_reset_only), .recover_from_prog(recover_from_prog),
    .sw_code(sw_code), .hw_code(hw_code), .prog_code(prog_code),
    .alarm(alarm), .sys_reset(sys_reset), .freq_code(freq_code));

  function automatic int exp_cycles(logic sl, logic [2:0] m);
    int u = sl ? 2340 * KHZ : 294 * KHZ;
    return (m == 3'd0) ? u : int'(m) * u;
  endfunction

  function automatic logic [CW-1:0] exp_code(logic act, logic src, logic [CW-1:0] sw,
                                             logic [CW-1:0] hw, logic [CW-1:0] pg);
    return act ? sw : (src ? pg : hw);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write(logic en, logic sl, logic [2:0] m, logic act, logic src);
    @(negedge clk);
    wd_enable = en; scale_long = sl; timeout_mult = m;
    action_reset_only = act; recover_from_prog = src; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_rise(int limit, output int n, output bit seen);
    seen = 1'b0; n = 0;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (sys_reset) begin seen = 1'b1; n = k; break; end
    end
  endtask

  task automatic pulse_width(output int w);
    w = 1;
    while (sys_reset && w < 100) begin
      @(negedge clk);
      if (sys_reset) w++;
    end
  endtask

  task automatic trial(logic sl, logic [2:0] m, logic act, logic src, string req);
    int n, w, e;
    bit seen;
    logic [CW-1:0] ec;
    e = exp_cycles(sl, m);
    ec = exp_code(act, src, sw_code, hw_code, prog_code);
    write(1'b1, sl, m, act, src);
    wait_rise(e + 50, n, seen);
    check(seen && n == e, req, n, e);
    check(alarm === 1'b1, "R6 alarm at expiry", int'(alarm), 1);
    check(freq_code === ec, act ? "R8 no restore" : "R9 restore source",
          int'(freq_code), int'(ec));
    pulse_width(w);
    check(w == RLEN, "R7 pulse width", w, RLEN);
    write(1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
    check(alarm === 1'b0, "R6 alarm cleared by field 000", int'(alarm), 0);
    check(freq_code === sw_code, "R10 release after write", int'(freq_code), int'(sw_code));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, w;
    bit seen;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(alarm === 1'b0 && sys_reset === 1'b0, "R1 reset outputs", int'({alarm, sys_reset}), 0);
    check(freq_code === sw_code, "R1 reset freq", int'(freq_code), int'(sw_code));
    rst_n = 1'b1;
    @(negedge clk);

    trial(1'b0, 3'd2, 1'b0, 1'b0, "R2 short x2");
    trial(1'b0, 3'd0, 1'b0, 1'b1, "R3 test mode");
    trial(1'b1, 3'd1, 1'b1, 1'b0, "R2 long x1");
    trial(1'b0, 3'd7, 1'b1, 1'b1, "R2 short x7");

    write(1'b1, 1'b0, 3'd2, 1'b0, 1'b0);
    wait_rise(400, n, seen);
    check(!seen, "R4 no reset before service", n, 0);
    trial(1'b0, 3'd2, 1'b0, 1'b0, "R4 period restarts after service");

    write(1'b1, 1'b0, 3'd1, 1'b0, 1'b0);
    repeat (100) @(negedge clk);
    write(1'b0, 1'b0, 3'd1, 1'b0, 1'b0);
    wait_rise(700, n, seen);
    check(!seen, "R5 disabled no reset", n, 0);
    check(alarm === 1'b0, "R5 disabled no alarm", int'(alarm), 0);

    write(1'b1, 1'b0, 3'd1, 1'b0, 1'b1);
    wait_rise(400, n, seen);
    pulse_width(w);
    write(1'b0, 1'b0, 3'd3, 1'b0, 1'b0);
    check(alarm === 1'b1, "R6 alarm kept by nonzero field", int'(alarm), 1);
    write(1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
    check(alarm === 1'b0, "R6 alarm cleared", int'(alarm), 0);

    for (int i = 0; i < 10; i++) begin
      logic [2:0] m;
      logic sl, act, src;
      m = 3'($urandom_range(0, 7));
      sl = ($urandom_range(0, 7) == 0);
      act = 1'($urandom);
      src = 1'($urandom);
      sw_code = CW'($urandom);
      hw_code = CW'($urandom);
      prog_code = CW'($urandom);
      if (sl && m > 3'd2) m = 3'd2;
      trial(sl, m, act, src, (m == 3'd0) ? "R3 random" : "R2 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule